// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is a single bus-master channel that moves audio sample words between system memory and a codec-side sample port. Software writes the address of a descriptor table and a small command nibble. The channel then walks the table and reads two 32-bit words per entry. The first word is a buffer address. The second word carries a byte count and three sequencing flags. For each data entry the channel streams the buffer one 32-bit word at a time. In playback the words go from memory to the codec port. In record they go from the codec port to memory.

The flags shape the walk through the table. A jump entry sends the walk to a new table address and moves no data, so a table can close on itself to form an endless ring. An end-of-page entry raises a status bit and the interrupt when its last word is done, and the walk continues. An end-of-table entry stops the channel once its data is through. The channel can be paused and later resumed at the exact word where it stopped. It can also be disabled, and the next enable after a disable restarts at the table address. Status bits clear when they are read. The interrupt also appears at a fixed bit of a shared interrupt word.

Top module: `pcm_ring_dma`

## Requirements
- R1: A descriptor is two words fetched from consecutive addresses, starting at the table address and advancing by 8 per entry. Word 0 is the buffer address. Word 1 bit 31 marks end-of-table, bit 30 marks end-of-page, bit 29 marks jump, and bits CNT_W-1:0 hold the byte count. The count is taken in whole 32-bit words, so its two low bits are ignored. In playback the buffer words go out on the codec port in address order. While a memory request waits for its acknowledge, its address is held, and a word offered to the codec is held until it is accepted.
- R2: A jump entry moves no data. The next descriptor is fetched from the address in its word 0.
- R3: When the last word of an end-of-page entry completes, status bit 0 and `irq` are set and the walk continues. An entry without this flag sets nothing.
- R4: When the last word of an end-of-table entry completes, the channel stops. It issues no further memory requests and the control field reads back 00.
- R5: Command bits 1:0 select the run state: 01 runs, 11 pauses, and 00 or 10 disables. While paused, no new memory request or codec word is started and the pointer stays put. A later 01 resumes the word stream without losing or repeating a word.
- R6: A disable drops the entry in progress. The next enable fetches from the table address, so the first data word is word 0 of the first buffer.
- R7: Command bit 2 set makes the channel exchange the two bytes inside each 16-bit half of every moved word. When it is clear, words pass unchanged.
- R8: Command bit 3 set selects record. Each word accepted from the codec port is written to consecutive buffer addresses starting at the buffer address.
- R9: A non-jump entry whose count holds zero whole words sets status bit 1 and `irq`, moves no data, and forces the control field to 00.
- R10: A status read pulse returns the current bits. They clear on the next cycle unless a new event sets them in that same cycle, and `irq` falls with them.
- R11: `irq_word` carries `irq` at bit CHAN_ID+2 and is zero at every other bit.
- R12: `cur_addr` reads 0 after reset. It loads the buffer address when a data entry starts and steps by 4 per completed word, so it ends at buffer address plus byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command: [1:0] run state, [2] byte exchange, [3] record |
| base_we | input | 1 | Table address write strobe |
| base_wdata | input | 32 | Descriptor table address |
| stat_rd | input | 1 | Status read pulse (clears the status) |
| cmd_q | output | 4 | Command readback |
| table_base | output | 32 | Table address readback |
| cur_addr | output | 32 | Address of the current buffer word |
| status | output | 2 | [0] end-of-page seen, [1] descriptor error |
| irq | output | 1 | Channel interrupt request |
| irq_word | output | IRQ_W | Shared interrupt word slice |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge (one cycle) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Playback word valid |
| tx_data | output | 32 | Playback word |
| tx_ready | input | 1 | Codec accepts the playback word |
| rx_valid | input | 1 | Record word valid |
| rx_data | input | 32 | Record word |
| rx_ready | output | 1 | Channel accepts the record word |

## Verification
The hardest state to reach from the ports is a pause or disable that lands while a ring lap is in flight. In that state a memory read may be pending, a word may be waiting at the codec, or the walk may sit just past the jump entry. The stimulus runs the closed ring against a memory with random latency and a codec that drops its ready at random, and lets it complete more than two laps. It then issues pause, resume and disable at arbitrary points. Each time it compares the whole collected stream with a stream built independently by walking the table. Random short chains follow, with an optional forward jump, a random byte-exchange setting and a final end-of-table entry.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_A,
    S_FETCH_B,
    S_MEM_RD,
    S_CODEC_TX,
    S_CODEC_RX,
    S_MEM_WR
  } dma_state_t;

  typedef enum logic [1:0] {
    PRD_DATA,
    PRD_JUMP,
    PRD_BAD
  } prd_kind_t;

  localparam int FLAG_EOT = 31;
  localparam int FLAG_EOP = 30;
  localparam int FLAG_JMP = 29;

  localparam logic [1:0] RUN_OFF   = 2'b00;
  localparam logic [1:0] RUN_GO    = 2'b01;
  localparam logic [1:0] RUN_PAUSE = 2'b11;

  // Descriptor pointer advance: two 32-bit words per entry.
  function automatic logic [31:0] next_desc(input logic [31:0] ptr);
    return ptr + 32'd8;
  endfunction

  // Buffer pointer advance: one 32-bit sample word.
  function automatic logic [31:0] next_word(input logic [31:0] ptr);
    return ptr + 32'd4;
  endfunction

  // Channel keeps its place in the table (run or pause).
  function automatic logic holds_place(input logic [1:0] ctrl);
    return ctrl[0];
  endfunction

endpackage

// File: rtl/prd_classify.sv
module prd_classify
  import pcm_dma_pkg::*;
#(
  parameter int CNT_W  = 17,
  localparam int WORD_W = CNT_W - 2
) (
  input  logic [2:0]        flags_i,  // {eot, eop, jmp}
  input  logic [WORD_W-1:0] words_i,
  output prd_kind_t         kind_o,
  output logic              eot_o,
  output logic              eop_o
);

  always_comb begin
    eot_o = flags_i[2];
    eop_o = flags_i[1];
    if (flags_i[0])
      kind_o = PRD_JUMP;
    else if (words_i == '0)
      kind_o = PRD_BAD;
    else
      kind_o = PRD_DATA;
  end

endmodule

// File: rtl/byte_lane_swap.sv
module byte_lane_swap #(
  parameter int W     = 32,
  parameter int LANE  = 8,
  parameter int GROUP = 16,
  localparam int NGRP = W / GROUP,
  localparam int LPG  = GROUP / LANE
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar b = 0; b < LPG; b++) begin : g_lane
      assign dout[g*GROUP + b*LANE +: LANE] =
        en ? din[g*GROUP + (LPG-1-b)*LANE +: LANE]
           : din[g*GROUP + b*LANE +: LANE];
    end
  end

endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int CHAN_ID = 0,
  parameter int IRQ_W   = 16,
  localparam int IRQ_BIT = CHAN_ID + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_eop,
  input  logic             set_err,
  input  logic             rd_clr,
  output logic [1:0]       status_q,
  output logic             irq,
  output logic [IRQ_W-1:0] irq_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_q <= 2'b00;
    else
      status_q <= (status_q & {2{~rd_clr}}) | {set_err, set_eop};
  end

  assign irq = |status_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_word
    if (i == IRQ_BIT) begin : g_hit
      assign irq_word[i] = irq;
    end else begin : g_zero
      assign irq_word[i] = 1'b0;
    end
  end

endmodule

// File: rtl/pcm_ring_dma.sv
module pcm_ring_dma
  import pcm_dma_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int CNT_W   = 17,
  parameter int IRQ_W   = 16,
  localparam int WORD_W = CNT_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [3:0]       cmd_wdata,
  input  logic             base_we,
  input  logic [31:0]      base_wdata,
  input  logic             stat_rd,
  output logic [3:0]       cmd_q,
  output logic [31:0]      table_base,
  output logic [31:0]      cur_addr,
  output logic [1:0]       status,
  output logic             irq,
  output logic [IRQ_W-1:0] irq_word,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [31:0]      rx_data,
  output logic             rx_ready
);

  dma_state_t         state_q;
  logic [1:0]         ctrl_q;
  logic               swap_q, rec_q;
  logic [31:0]        base_q, fetch_q, w0_q, addr_q, data_q;
  logic [WORD_W-1:0]  left_q;
  logic               eot_q, eop_q, held_q;

  logic               go, keep, req_state, last_word;
  prd_kind_t          kind;
  logic               dec_eot, dec_eop;
  logic [31:0]        swap_in, swap_out;

  // named internal events
  logic ev_desc_ok, ev_jump, ev_err, ev_load, ev_word, ev_desc_end, ev_eop, ev_eot;

  assign go   = (ctrl_q == RUN_GO);
  assign keep = holds_place(ctrl_q);

  prd_classify #(.CNT_W(CNT_W)) u_cls (
    .flags_i ({mem_rdata[FLAG_EOT], mem_rdata[FLAG_EOP], mem_rdata[FLAG_JMP]}),
    .words_i (mem_rdata[CNT_W-1:2]),
    .kind_o  (kind),
    .eot_o   (dec_eot),
    .eop_o   (dec_eop)
  );

  assign swap_in = (state_q == S_CODEC_RX) ? rx_data : mem_rdata;

  byte_lane_swap #(.W(32), .LANE(8), .GROUP(16)) u_swap (
    .en   (swap_q),
    .din  (swap_in),
    .dout (swap_out)
  );

  assign req_state = (state_q == S_FETCH_A) || (state_q == S_FETCH_B) ||
                     (state_q == S_MEM_RD)  || (state_q == S_MEM_WR);
  assign mem_req   = req_state && (go || held_q);
  assign mem_we    = (state_q == S_MEM_WR);
  assign mem_wdata = data_q;
  always_comb begin
    unique case (state_q)
      S_FETCH_A: mem_addr = fetch_q;
      S_FETCH_B: mem_addr = next_word(fetch_q);
      default:   mem_addr = addr_q;
    endcase
  end

  assign tx_valid = (state_q == S_CODEC_TX);
  assign tx_data  = data_q;
  assign rx_ready = (state_q == S_CODEC_RX) && go;

  assign last_word   = (left_q == WORD_W'(1));
  assign ev_desc_ok  = (state_q == S_FETCH_B) && mem_ack && keep;
  assign ev_jump     = ev_desc_ok && (kind == PRD_JUMP);
  assign ev_err      = ev_desc_ok && (kind == PRD_BAD);
  assign ev_load     = ev_desc_ok && (kind == PRD_DATA);
  assign ev_word     = keep && (((state_q == S_CODEC_TX) && tx_ready) ||
                                ((state_q == S_MEM_WR) && mem_ack));
  assign ev_desc_end = ev_word && last_word;
  assign ev_eop      = ev_desc_end && eop_q;
  assign ev_eot      = ev_desc_end && eot_q;

  // command and table registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RUN_OFF;
      swap_q <= 1'b0;
      rec_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (cmd_we) begin
        ctrl_q <= cmd_wdata[1:0];
        swap_q <= cmd_wdata[2];
        rec_q  <= cmd_wdata[3];
      end else if (ev_eot || ev_err) begin
        ctrl_q <= RUN_OFF;
      end
      if (base_we) base_q <= base_wdata;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fetch_q <= '0;
      w0_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      left_q  <= '0;
      eot_q   <= 1'b0;
      eop_q   <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      held_q <= mem_req && !mem_ack && keep;
      if (!keep) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (go) begin
            fetch_q <= base_q;
            state_q <= S_FETCH_A;
          end
          S_FETCH_A: if (mem_ack) begin
            w0_q    <= mem_rdata;
            state_q <= S_FETCH_B;
          end
          S_FETCH_B: if (mem_ack) begin
            unique case (kind)
              PRD_JUMP: begin
                fetch_q <= w0_q;
                state_q <= S_FETCH_A;
              end
              PRD_BAD: state_q <= S_IDLE;
              default: begin
                addr_q  <= w0_q;
                left_q  <= mem_rdata[CNT_W-1:2];
                eot_q   <= dec_eot;
                eop_q   <= dec_eop;
                fetch_q <= next_desc(fetch_q);
                state_q <= rec_q ? S_CODEC_RX : S_MEM_RD;
              end
            endcase
          end
          S_MEM_RD: if (mem_ack) begin
            data_q  <= swap_out;
            state_q <= S_CODEC_TX;
          end
          S_CODEC_RX: if (rx_valid && rx_ready) begin
            data_q  <= swap_out;
            state_q <= S_MEM_WR;
          end
          S_CODEC_TX, S_MEM_WR: if (ev_word) begin
            addr_q <= next_word(addr_q);
            left_q <= left_q - WORD_W'(1);
            if (last_word)
              state_q <= eot_q ? S_IDLE : S_FETCH_A;
            else
              state_q <= (state_q == S_MEM_WR) ? S_CODEC_RX : S_MEM_RD;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  dma_status #(.CHAN_ID(CHAN_ID), .IRQ_W(IRQ_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_eop  (ev_eop),
    .set_err  (ev_err),
    .rd_clr   (stat_rd),
    .status_q (status),
    .irq      (irq),
    .irq_word (irq_word)
  );

  assign cmd_q      = {rec_q, swap_q, ctrl_q};
  assign table_base = base_q;
  assign cur_addr   = addr_q;

endmodule

// File: rtl/pcm_ring_dma_chk.sv
module pcm_ring_dma_chk #(
  parameter int CHAN_ID = 0,
  parameter int IRQ_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [3:0]       cmd_q,
  input logic [1:0]       status,
  input logic             stat_rd,
  input logic             irq,
  input logic [IRQ_W-1:0] irq_word,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic             mem_ack,
  input logic             tx_valid,
  input logic [31:0]      tx_data,
  input logic             tx_ready,
  input logic             rx_ready,
  input logic             ev_eop,
  input logic             ev_eot,
  input logic             ev_err,
  input logic             ev_jump
);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && cmd_q[0] |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && cmd_q[0] |=> tx_valid && $stable(tx_data)); // R1

  AST_JUMP_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> !tx_valid && !mem_we); // R2

  AST_EOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |=> status[0] && irq); // R3

  AST_EOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eot && !cmd_we |=> cmd_q[1:0] == 2'b00 && !mem_req && !tx_valid); // R4

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[1:0] == 2'b11 && !cmd_we && !mem_req |=> !mem_req && !rx_ready); // R5

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err && !cmd_we |=> status[1] && cmd_q[1:0] == 2'b00); // R9

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ev_eop && !ev_err |=> status == 2'b00 && !irq); // R10

  AST_IRQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_word) && (irq_word[CHAN_ID+2] == irq)); // R11

endmodule

bind pcm_ring_dma pcm_ring_dma_chk #(.CHAN_ID(CHAN_ID), .IRQ_W(IRQ_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_we   (cmd_we),
  .cmd_q    (cmd_q),
  .status   (status),
  .stat_rd  (stat_rd),
  .irq      (irq),
  .irq_word (irq_word),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_ready (tx_ready),
  .rx_ready (rx_ready),
  .ev_eop   (ev_eop),
  .ev_eot   (ev_eot),
  .ev_err   (ev_err),
  .ev_jump  (ev_jump)
);

// File: tb/test_pcm_ring_dma.sv
`timescale 1ns/1ps
module test_pcm_ring_dma;

  localparam int CH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [3:0]  cmd_wdata = '0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [3:0]  cmd_q;
  logic [31:0] table_base, cur_addr;
  logic [1:0]  status;
  logic        irq;
  logic [15:0] irq_word;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = 32'h1234_0001;

  always #2.5 clk = ~clk;

  pcm_ring_dma #(.CHAN_ID(CH)) i_pcm_ring_dma (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .stat_rd(stat_rd),
    .cmd_q(cmd_q), .table_base(table_base), .cur_addr(cur_addr),
    .status(status), .irq(irq), .irq_word(irq_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [31:0] expq[$];
  int          lat = 0;
  bit          rdy_rand = 1'b0;
  int          n_chk = 0, n_fail = 0;

  // memory with random latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[13:2]];
        lat <= int'($urandom_range(0, 2));
      end else begin
        lat <= lat - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (tx_valid && tx_ready) txq.push_back(tx_data);
    if (rx_valid && rx_ready) begin
      rxq.push_back(rx_data);
      rx_data <= rx_data + 32'h0101_0103;
    end
  end

  always @(negedge clk) tx_ready <= rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;

  function automatic logic [31:0] flip(input logic [31:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  // independent walk of the descriptor table
  task automatic build_exp(input logic [31:0] tbl, input bit be, input int nmax);
    logic [31:0] p, a, f;
    int guard = 0;
    expq.delete();
    p = tbl;
    while (expq.size() < nmax && guard < 1000) begin
      guard++;
      a = mem[p[13:2]];
      f = mem[p[13:2] + 1];
      if (f[29]) begin p = a; continue; end
      for (int i = 0; i < int'(f[16:2]) && expq.size() < nmax; i++)
        expq.push_back(be ? flip(mem[a[13:2] + i]) : mem[a[13:2] + i]);
      if (f[31]) break;
      p = p + 8;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] a);
    @(negedge clk); base_we = 1'b1; base_wdata = a;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic read_status(output logic [1:0] v);
    @(negedge clk); v = status; stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    int t = 0;
    while (txq.size() < n && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_stop();
    int t = 0;
    while (cmd_q[1:0] != 2'b00 && t < 20000) begin @(negedge clk); t++; end
    idle(5);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] a, input logic [31:0] f);
    mem[at[13:2]]     = a;
    mem[at[13:2] + 1] = f;
  endtask

  task automatic cmp_stream(input string tag, input bit be, input logic [31:0] tbl);
    int bad = 0;
    build_exp(tbl, be, txq.size());
    for (int i = 0; i < txq.size(); i++)
      if (i >= expq.size() || txq[i] !== expq[i]) bad++;
    check(bad == 0 && txq.size() == expq.size(), tag, bad, 0);
  endtask

  localparam logic [31:0] EOT = 32'h8000_0000, EOP = 32'h4000_0000, JMP = 32'h2000_0000;

  initial begin
    logic [1:0]  st;
    logic [31:0] snap_a;
    int          snap_n;
    int          bad;
    process::self().srandom(32'd20240517);
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    rx_valid = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // reset state
    check(status == 2'b00 && !irq && irq_word == 16'h0, "R10 reset status", {30'd0, status}, 0);
    check(!mem_req && !tx_valid && !rx_ready, "R4 reset idle", {29'd0, mem_req, tx_valid, rx_ready}, 0);
    check(cur_addr == 32'h0 && cmd_q == 4'h0, "R12 reset pointer", cur_addr, 0);

    // ring: two data entries then a jump back to the start
    put_desc(32'h100, 32'h1000, EOP | 32'd64);
    put_desc(32'h108, 32'h1400, EOP | 32'd128);
    put_desc(32'h110, 32'h0100, JMP);
    rdy_rand = 1'b1;
    set_base(32'h100);
    cmd(4'b0001);
    wait_tx(110);
    cmd(4'b0011);
    idle(40);
    cmp_stream("R1 R2 ring playback over two laps", 1'b0, 32'h100);
    check(status[0] == 1'b1, "R3 end-of-page flag", {30'd0, status}, 1);
    check(irq_word == (16'h1 << (CH + 2)), "R11 shared interrupt bit", {16'd0, irq_word}, 32'h1 << (CH + 2));
    read_status(st);
    idle(2);
    check(st[0] == 1'b1 && status == 2'b00 && !irq, "R10 read clears", {30'd0, status}, 0);

    // pause holds position
    snap_n = txq.size();
    snap_a = cur_addr;
    idle(60);
    check(txq.size() == snap_n && cur_addr == snap_a, "R5 pause holds", cur_addr, snap_a);
    cmd(4'b0001);
    wait_tx(snap_n + 40);
    cmd(4'b0011);
    idle(40);
    cmp_stream("R5 resume continues stream", 1'b0, 32'h100);

    // disable then enable restarts at table base
    cmd(4'b0000);
    idle(10);
    check(!mem_req && !tx_valid, "R6 disabled quiet", {30'd0, mem_req, tx_valid}, 0);
    txq.delete();
    cmd(4'b0001);
    wait_tx(5);
    cmd(4'b0000);
    idle(10);
    bad = 0;
    for (int i = 0; i < 5; i++) if (txq[i] !== mem[32'h1000/4 + i]) bad++;
    check(bad == 0, "R6 restart from first buffer", txq[0], mem[32'h1000/4]);

    // byte exchange
    txq.delete();
    cmd(4'b0101);
    wait_tx(60);
    cmd(4'b0000);
    idle(10);
    cmp_stream("R7 byte exchange stream", 1'b1, 32'h100);

    // record into memory, end-of-table with end-of-page
    read_status(st);
    put_desc(32'h200, 32'h3000, EOT | EOP | 32'd64);
    set_base(32'h200);
    rxq.delete();
    cmd(4'b1001);
    wait_stop();
    bad = 0;
    for (int i = 0; i < 16; i++) if (rxq.size() != 16 || mem[32'h3000/4 + i] !== rxq[i]) bad++;
    check(bad == 0, "R8 record writes buffer", bad, 0);
    check(cmd_q[1:0] == 2'b00 && !mem_req, "R4 stop after table end", {28'd0, cmd_q}, 32'h8);
    check(status == 2'b01, "R3 record end-of-page", {30'd0, status}, 1);
    check(cur_addr == 32'h3040, "R12 pointer at buffer end", cur_addr, 32'h3040);

    // end-of-table without end-of-page
    read_status(st);
    put_desc(32'h280, 32'h1800, EOT | 32'd64);
    set_base(32'h280);
    txq.delete();
    cmd(4'b0001);
    wait_stop();
    cmp_stream("R1 single entry playback", 1'b0, 32'h280);
    check(txq.size() == 16 && status == 2'b00 && !irq, "R3 R4 no flag without end-of-page", {30'd0, status}, 0);
    check(cur_addr == 32'h1840, "R12 pointer end", cur_addr, 32'h1840);

    // zero-length entry
    put_desc(32'h300, 32'h1000, EOP | 32'd3);
    set_base(32'h300);
    txq.delete();
    cmd(4'b0001);
    idle(40);
    check(status == 2'b10 && cmd_q[1:0] == 2'b00 && txq.size() == 0, "R9 zero length error", {30'd0, status}, 2);
    check(irq && irq_word == (16'h1 << (CH + 2)), "R11 error interrupt", {16'd0, irq_word}, 32'h1 << (CH + 2));

    // random chains
    for (int it = 0; it < 8; it++) begin
      logic [31:0] p, b, last_end;
      bit          any_eop, be, jmp;
      int          nd;
      nd  = int'($urandom_range(1, 3));
      jmp = 1'($urandom_range(0, 1));
      be  = 1'($urandom_range(0, 1));
      any_eop = 1'b0;
      p = 32'h400;
      last_end = '0;
      for (int k = 0; k < nd; k++) begin
        logic [31:0] f;
        if (k == 1 && jmp) begin put_desc(p, 32'h480, JMP | 32'd64); p = 32'h480; end
        b = 32'h1000 + 32'h40 * $urandom_range(0, 40);
        f = 32'd64 * $urandom_range(1, 3);
        last_end = b + f;
        if ($urandom_range(0, 1) == 1) begin f = f | EOP; any_eop = 1'b1; end
        if (k == nd - 1) f = f | EOT;
        put_desc(p, b, f);
        p = p + 8;
      end
      read_status(st);
      set_base(32'h400);
      txq.delete();
      cmd({1'b0, be, 2'b01});
      wait_stop();
      cmp_stream("R1 R2 R7 random chain", be, 32'h400);
      check(status[0] == any_eop, "R3 random end-of-page", {30'd0, status}, {31'd0, any_eop});
      check(cur_addr == last_end, "R12 random pointer", cur_addr, last_end);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R1 act=%h exp=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule